// File: doc/BRIEF.md
# Windowed Threshold Alarm with Persistence Filter

This block watches a stream of 16-bit conversion results and raises an alarm when the readings leave a programmed window. A high and a low limit each come in as one byte. The byte supplies the upper half of a 16-bit compare value, and the lower half is implied zero. A result counts as outside the window when it is strictly greater than the high limit or strictly less than the low limit.

A single stray reading does not raise the alarm. A persistence code selects how many consecutive out-of-window results must arrive before the alarm fires, and any in-window result restarts that run. Once the alarm fires, it latches a status flag and pulls an active-low interrupt output low. Both stay set until the host clears them, either by writing 0 to the flag or by pulsing a dedicated clear strobe.

Top module: `lux_window_alarm`

## Requirements
- R1: The high compare value is `{thr_hi_i, 8'h00}`. A valid result strictly greater than this value is out of window. A result equal to it is in window.
- R2: The low compare value is `{thr_lo_i, 8'h00}`. A valid result strictly less than this value is out of window. A result equal to it is in window.
- R3: `persist_i` selects the number of consecutive out-of-window valid results that fire the alarm: code 0 needs 1, code 1 needs 4, code 2 needs 8 and code 3 needs 16. The flag rises on the clock edge that samples the last result of the run.
- R4: A valid in-window result resets the run of consecutive out-of-window results to zero.
- R5: The run count saturates at the required length. After a clear, each further out-of-window result in an unbroken run fires the alarm again at once.
- R6: `irq_n_o` is always the inverse of `flag_o`. Once set, the flag stays set through any later results until a clear is applied.
- R7: A cycle with `flag_wr_i`=1 and `flag_wr_val_i`=0 clears the flag. A cycle with `flag_wr_val_i`=1 leaves the flag unchanged.
- R8: A cycle with `irq_clr_i`=1 clears the flag and releases `irq_n_o` to 1.
- R9: When a clear and a firing result fall in the same cycle, the flag ends up set.
- R10: After reset, `flag_o` is 0, `irq_n_o` is 1 and the run count is zero.
- R11: When `sample_vld_i`=0, the value on `sample_i` has no effect on the run count or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 16 | Conversion result |
| sample_vld_i | input | 1 | Strobe that marks a new result |
| thr_hi_i | input | 8 | Upper byte of the high limit |
| thr_lo_i | input | 8 | Upper byte of the low limit |
| persist_i | input | 2 | Persistence code |
| flag_wr_i | input | 1 | Write strobe to the status flag |
| flag_wr_val_i | input | 1 | Value written to the flag (only 0 has an effect) |
| irq_clr_i | input | 1 | Clear-interrupt strobe |
| flag_o | output | 1 | Latched alarm status |
| irq_n_o | output | 1 | Active-low interrupt, open-drain style |

## Verification
The only hidden state is the run counter, so any error in it shows at the ports as a flag that rises one result too early or too late. A run counter that is not reset shows within one result of an in-window reading. A counter that fails to saturate shows on the first out-of-window result after a clear, because that result should fire the alarm again immediately. The bench checks the flag and the interrupt one clock after every stimulus cycle. It sweeps the limits around both boundaries, every persistence code, and the collisions between clears and firing results, so a defect appears in the first cycle in which it matters.

// File: rtl/lux_window_alarm.sv
module lux_window_alarm #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 8,
  parameter int PERS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_vld_i,
  input  logic [THR_W-1:0]  thr_hi_i,
  input  logic [THR_W-1:0]  thr_lo_i,
  input  logic [PERS_W-1:0] persist_i,
  input  logic              flag_wr_i,
  input  logic              flag_wr_val_i,
  input  logic              irq_clr_i,
  output logic              flag_o,
  output logic              irq_n_o
);
  localparam int PAD_W = DATA_W - THR_W;
  localparam int CNT_W = (2 ** PERS_W) + 1;

  logic [DATA_W-1:0] hi_lim, lo_lim;
  logic [CNT_W-1:0]  need, cnt_q, bump;
  logic              outside, fire, wipe, flag_q;

  assign hi_lim  = {thr_hi_i, {PAD_W{1'b0}}};
  assign lo_lim  = {thr_lo_i, {PAD_W{1'b0}}};
  assign outside = (sample_i > hi_lim) || (sample_i < lo_lim);

  always_comb begin
    if (persist_i == '0) need = CNT_W'(1);
    else                 need = CNT_W'(1) << ({1'b0, persist_i} + (PERS_W+1)'(1));
  end

  assign bump = cnt_q + CNT_W'(1);
  assign fire = sample_vld_i && outside && (bump >= need);
  assign wipe = irq_clr_i || (flag_wr_i && !flag_wr_val_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (sample_vld_i) cnt_q <= !outside ? '0 : (bump >= need ? need : bump);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (fire) flag_q <= 1'b1;
    else if (wipe) flag_q <= 1'b0;
  end

  assign flag_o  = flag_q;
  assign irq_n_o = ~flag_q;
endmodule

// File: rtl/lux_window_alarm_chk.sv
module lux_window_alarm_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_vld_i,
  input logic             flag_wr_i,
  input logic             flag_wr_val_i,
  input logic             irq_clr_i,
  input logic             flag_o,
  input logic             irq_n_o,
  input logic             fire,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] need
);
  assert_irq_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o == !flag_o);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !irq_clr_i && !(flag_wr_i && !flag_wr_val_i) |=> flag_o);

  assert_strobe_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_i && !sample_vld_i |=> !flag_o && irq_n_o);

  assert_zero_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_i && !flag_wr_val_i && !sample_vld_i |=> !flag_o);

  assert_fire_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag_o);

  assert_rise_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_o && !sample_vld_i |=> !flag_o);

  assert_count_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld_i |=> $stable(cnt_q) || (cnt_q <= need));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_i |=> cnt_q <= 5'd16);
endmodule

bind lux_window_alarm lux_window_alarm_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld_i(sample_vld_i),
  .flag_wr_i(flag_wr_i), .flag_wr_val_i(flag_wr_val_i), .irq_clr_i(irq_clr_i),
  .flag_o(flag_o), .irq_n_o(irq_n_o), .fire(fire), .cnt_q(cnt_q), .need(need)
);

// File: tb/test_lux_window_alarm.sv
module test_lux_window_alarm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sample_i = '0;
  logic        sample_vld_i = 1'b0;
  logic [7:0]  thr_hi_i = 8'hFF;
  logic [7:0]  thr_lo_i = 8'h00;
  logic [1:0]  persist_i = '0;
  logic        flag_wr_i = 1'b0, flag_wr_val_i = 1'b0, irq_clr_i = 1'b0;
  logic        flag_o, irq_n_o;

  int checks = 0, failures = 0, cycles = 0;
  int m_cnt = 0;
  bit m_flag = 0;

  lux_window_alarm i_lux_window_alarm (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int need_of(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (flag_o !== m_flag || irq_n_o !== !m_flag) begin
      failures++;
      $display("FAIL %s: actual flag=%b irq_n=%b expected flag=%b irq_n=%b",
               tag, flag_o, irq_n_o, m_flag, !m_flag);
    end
  endtask

  task automatic cyc(input logic [15:0] s, input bit vld, input bit clr,
                     input bit wr, input bit wv, input string tag);
    bit out_w, fire;
    @(negedge clk);
    sample_i = s; sample_vld_i = vld; irq_clr_i = clr;
    flag_wr_i = wr; flag_wr_val_i = wv;
    out_w = (s > {thr_hi_i, 8'h00}) || (s < {thr_lo_i, 8'h00});
    fire = 0;
    if (vld) begin
      if (out_w) begin
        m_cnt = (m_cnt + 1 > need_of(persist_i)) ? need_of(persist_i) : m_cnt + 1;
        fire = (m_cnt >= need_of(persist_i));
      end else m_cnt = 0;
    end
    if (fire) m_flag = 1;
    else if (clr || (wr && !wv)) m_flag = 0;
    @(negedge clk);
    sample_vld_i = 0; irq_clr_i = 0; flag_wr_i = 0; sample_i = 16'h5A5A;
    check(tag);
  endtask

  task automatic clear_all();
    cyc(16'h8000, 0, 1, 0, 0, "R8");
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check("R10");
    rst_n = 1'b1;
    @(negedge clk);
    check("R10");

    // R1 / R2 boundary sweep, persistence code 0
    foreach (thr_hi_i[b]) begin end
    for (int h = 1; h < 256; h += 17) begin
      thr_hi_i = 8'(h); thr_lo_i = 8'(h - 1);
      for (int d = -2; d <= 2; d++) begin
        cyc(16'({h, 8'h00} + d), 1, 0, 0, 0, "R1");
        clear_all();
        cyc(16'({h - 1, 8'h00} + d), 1, 0, 0, 0, "R2");
        clear_all();
      end
    end
    thr_hi_i = 8'h80; thr_lo_i = 8'h20;

    // R3 exact lengths for every code, R4 restart, R11 ignored invalid
    for (int c = 0; c < 4; c++) begin
      persist_i = 2'(c);
      cyc(16'h5000, 1, 0, 0, 0, "R4");
      for (int k = 1; k < need_of(2'(c)); k++) begin
        cyc(16'hF000, 1, 0, 0, 0, "R3");
        cyc(16'hFFFF, 0, 0, 0, 0, "R11");
      end
      cyc(16'h0000, 1, 0, 0, 0, "R3");
      clear_all();
      if (c > 0) begin
        for (int k = 1; k < need_of(2'(c)); k++) cyc(16'hF000, 1, 0, 0, 0, "R4");
        cyc(16'h4000, 1, 0, 0, 0, "R4");
        cyc(16'hF000, 1, 0, 0, 0, "R4");
      end
      // R5 saturation: refire right after a clear
      for (int k = 0; k < need_of(2'(c)) + 3; k++) cyc(16'hF000, 1, 0, 0, 0, "R5");
      cyc(16'h4000, 0, 1, 0, 0, "R8");
      cyc(16'hF000, 1, 0, 0, 0, "R5");
      // R6 sticky through in-window results
      cyc(16'h4000, 1, 0, 0, 0, "R6");
      cyc(16'h4000, 1, 0, 1, 1, "R7");
      cyc(16'h4000, 1, 0, 1, 0, "R7");
      // R9 clear against a firing result
      for (int k = 1; k < need_of(2'(c)); k++) cyc(16'hF000, 1, 0, 0, 0, "R9");
      cyc(16'hF000, 1, 1, 0, 0, "R9");
      cyc(16'hF000, 1, 0, 1, 0, "R9");
      clear_all();
    end

    // R10 mid-run reset returns run count to zero
    persist_i = 2'd1;
    cyc(16'hF000, 1, 0, 0, 0, "R10");
    cyc(16'hF000, 1, 0, 0, 0, "R10");
    @(negedge clk); rst_n = 0; m_cnt = 0; m_flag = 0;
    @(negedge clk); rst_n = 1; check("R10");
    for (int k = 0; k < 4; k++) cyc(16'hF000, 1, 0, 0, 0, "R10");

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 0) persist_i = lfsr[5:4];
      if (lfsr[9:6] == 0) begin thr_hi_i = lfsr[15:8] | 8'h40; thr_lo_i = lfsr[7:0] & 8'h3F; end
      cyc({lfsr[7:0], lfsr[15:8]}, lfsr[1] | lfsr[2], lfsr[11] & lfsr[12] & lfsr[13],
          lfsr[14] & lfsr[9], lfsr[0], "R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule